// File: doc/BRIEF.md
# Debug wire mode-switch sequence generator

This block drives one serial debug data/mode line with a fixed special bit pattern. The patterns reset the two-wire debug link and move a target's debug interface between the JTAG state, the serial-wire state and the low-power dormant state. A one-cycle start strobe and a 3-bit select code choose the pattern. The block then shifts it out least significant bit first, one bit per debug clock cycle, and raises a clock-enable for every bit so that the surrounding logic can gate the debug clock.

Each pattern is computed from compact internal constants: the run lengths of the segments, a few short switch codes, and the 128-bit selection alert. No per-bit table is stored. A single-cycle done pulse marks the end of a pattern. A reserved select code is refused with a single-cycle error pulse, and no clock-enable is produced for it.

Top module: `dbg_seq_gen`

## Requirements
- R1: During and after reset, with no start, busy_o, done_o, err_o and clk_en_o are 0, and swdio_o holds the idle level (0 by default).
- R2: A start_i sampled while idle with a valid select has the following effect from the next cycle. busy_o and clk_en_o stay high for exactly the length of the pattern. Bit k of the pattern is on swdio_o in cycle k after the start edge, counting from 0.
- R3: Select 0 (link reset) is 64 bits: 56 ones, then 8 zeros.
- R4: Select 1 (JTAG to serial wire) is 136 bits: 56 ones, then 16'hE79E sent LSB first, then the 64-bit link reset of R3.
- R5: Select 2 (serial wire to JTAG) is 80 bits: 56 ones, then 16'hE73C sent LSB first, then 8 ones.
- R6: Select 3 (serial wire to dormant) is 72 bits: 56 ones, then 16'hE3BC sent LSB first.
- R7: Select 4 (dormant to serial wire) is 224 bits. It sends 8 ones, the selection alert, 4 zeros, and the activation code 8'h1A LSB first. It ends with 68 ones and then 8 zeros.
- R8: Select 5 (JTAG to dormant) is 40 bits: 9 ones, then bits 0 to 30 of 32'h33BBBBBA, LSB first.
- R9: Select 6 (dormant to JTAG) is 160 bits. It sends 8 ones and the selection alert, then 12 zeros of activation code and 12 more zeros.
- R10: The selection alert is 128 bits. Sent LSB first per byte, its bytes in wire order are 92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19.
- R11: done_o is high for exactly one cycle, the cycle after the last bit, and busy_o is low in that cycle.
- R12: A start with select 7 (reserved) gives err_o high for one cycle in the next cycle. busy_o and clk_en_o stay low, and swdio_o stays at the idle level.
- R13: A start_i while busy_o is high is ignored. The running pattern continues unchanged, and no new pattern follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| sel_i | input | 3 | Pattern select code |
| swdio_o | output | 1 | Driven data/mode line |
| clk_en_o | output | 1 | High in every cycle that carries a pattern bit |
| busy_o | output | 1 | A pattern is being sent |
| done_o | output | 1 | One-cycle end-of-pattern pulse |
| err_o | output | 1 | One-cycle reserved-select pulse |

## Verification
Every output comes from registers, so a result is due in the cycle after the rising edge that caused it. The first bit, busy and error each follow the start edge by one cycle. Done follows the edge on which the last bit was consumed, which is the pattern length in cycles after start. The reference model advances on the rising edge, inputs change on the falling edge, and outputs are compared on the falling edge, so each comparison falls mid-cycle in exactly the cycle the result is due.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_LINK_RESET   = 3'd0,
    SEQ_JTAG_TO_SW   = 3'd1,
    SEQ_SW_TO_JTAG   = 3'd2,
    SEQ_SW_TO_DORM   = 3'd3,
    SEQ_DORM_TO_SW   = 3'd4,
    SEQ_JTAG_TO_DORM = 3'd5,
    SEQ_DORM_TO_JTAG = 3'd6,
    SEQ_RESERVED     = 3'd7
  } seq_e;

  localparam int MAX_LEN = 224;
  localparam int IDX_W   = $clog2(MAX_LEN);

  localparam int HI_RUN  = 56;   // padded high run before a switch code
  localparam int LR_LEN  = 64;   // link reset length
  localparam int CODE_W  = 16;
  localparam int WAKE_HI = 8;    // high run before the alert
  localparam int ALERT_W = 128;

  localparam logic [15:0]  CODE_J2S = 16'hE79E;
  localparam logic [15:0]  CODE_S2J = 16'hE73C;
  localparam logic [15:0]  CODE_S2D = 16'hE3BC;
  localparam logic [7:0]   ACT_SW   = 8'h1A;
  localparam logic [30:0]  CODE_J2D = 31'h33BBBBBA;
  localparam logic [127:0] ALERT    = 128'h19BC0EA2E3DDAFE986852D956209F392;

  function automatic logic [IDX_W-1:0] seq_len(seq_e s);
    case (s)
      SEQ_LINK_RESET:   return IDX_W'(LR_LEN);
      SEQ_JTAG_TO_SW:   return IDX_W'(HI_RUN + CODE_W + LR_LEN);
      SEQ_SW_TO_JTAG:   return IDX_W'(HI_RUN + CODE_W + 8);
      SEQ_SW_TO_DORM:   return IDX_W'(HI_RUN + CODE_W);
      SEQ_DORM_TO_SW:   return IDX_W'(MAX_LEN);
      SEQ_JTAG_TO_DORM: return IDX_W'(40);
      SEQ_DORM_TO_JTAG: return IDX_W'(WAKE_HI + ALERT_W + 24);
      default:          return '0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_seq_bits.sv
module dbg_seq_bits
  import dbg_seq_pkg::*;
(
  input  seq_e             sel_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);

  localparam int CODE_END  = HI_RUN + CODE_W;
  localparam int ALERT_END = WAKE_HI + ALERT_W;
  localparam int ACT_BEG   = ALERT_END + 4;
  localparam int ACT_END   = ACT_BEG + 8;
  localparam int TAIL_LOW  = MAX_LEN - 8;
  localparam int J2D_HI    = 9;

  function automatic logic link_reset_bit(int j);
    return j < HI_RUN;
  endfunction

  always_comb begin
    int i;
    i = int'(idx_i);
    bit_o = 1'b0;
    case (sel_i)
      SEQ_LINK_RESET: bit_o = link_reset_bit(i);
      SEQ_JTAG_TO_SW:
        if (i < HI_RUN)        bit_o = 1'b1;
        else if (i < CODE_END) bit_o = CODE_J2S[4'(i - HI_RUN)];
        else                   bit_o = link_reset_bit(i - CODE_END);
      SEQ_SW_TO_JTAG:
        if (i < HI_RUN)        bit_o = 1'b1;
        else if (i < CODE_END) bit_o = CODE_S2J[4'(i - HI_RUN)];
        else                   bit_o = 1'b1;
      SEQ_SW_TO_DORM:
        if (i < HI_RUN)        bit_o = 1'b1;
        else                   bit_o = CODE_S2D[4'(i - HI_RUN)];
      SEQ_DORM_TO_SW:
        if (i < WAKE_HI)        bit_o = 1'b1;
        else if (i < ALERT_END) bit_o = ALERT[7'(i - WAKE_HI)];
        else if (i < ACT_BEG)   bit_o = 1'b0;
        else if (i < ACT_END)   bit_o = ACT_SW[3'(i - ACT_BEG)];
        else                    bit_o = i < TAIL_LOW;
      SEQ_JTAG_TO_DORM:
        if (i < J2D_HI)        bit_o = 1'b1;
        else                   bit_o = CODE_J2D[5'(i - J2D_HI)];
      SEQ_DORM_TO_JTAG:
        if (i < WAKE_HI)        bit_o = 1'b1;
        else if (i < ALERT_END) bit_o = ALERT[7'(i - WAKE_HI)];
        else                    bit_o = 1'b0;
      default: bit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_seq_ctrl.sv
module dbg_seq_ctrl
  import dbg_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  seq_e             sel_i,
  output seq_e             sel_q_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  logic [IDX_W-1:0] last_idx;
  assign last_idx = seq_len(sel_q_o) - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q_o <= SEQ_LINK_RESET;
      idx_o   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (busy_o) begin
        if (idx_o == last_idx) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          idx_o  <= '0;
        end else begin
          idx_o <= idx_o + IDX_W'(1);
        end
      end else if (start_i) begin
        if (sel_i == SEQ_RESERVED) begin
          err_o <= 1'b1;
        end else begin
          sel_q_o <= sel_i;
          idx_o   <= '0;
          busy_o  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dbg_seq_gen.sv
module dbg_seq_gen
  import dbg_seq_pkg::*;
#(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] sel_i,
  output logic       swdio_o,
  output logic       clk_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);

  seq_e             sel_q;
  logic [IDX_W-1:0] idx;
  logic             seq_bit;

  dbg_seq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sel_i   (seq_e'(sel_i)),
    .sel_q_o (sel_q),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  dbg_seq_bits u_bits (
    .sel_i (sel_q),
    .idx_i (idx),
    .bit_o (seq_bit)
  );

  assign swdio_o  = busy_o ? seq_bit : IDLE_LEVEL;
  assign clk_en_o = busy_o;

endmodule

// File: rtl/dbg_seq_gen_chk.sv
module dbg_seq_gen_chk
  import dbg_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] sel_i,
  input logic       swdio_o,
  input logic       clk_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);

  logic             accept;
  logic [IDX_W:0]   run_cnt;
  seq_e             sel_lat;

  assign accept = start_i && !busy_o && (sel_i != 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
      sel_lat <= SEQ_LINK_RESET;
    end else if (accept) begin
      run_cnt <= '0;
      sel_lat <= seq_e'(sel_i);
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && clk_en_o));

  assert_first_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> swdio_o);

  assert_len_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == (IDX_W+1)'(seq_len(sel_lat))));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_reserved_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && sel_i == 3'd7) |=> (err_o && !busy_o && !clk_en_o));

  assert_err_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_ignore_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

bind dbg_seq_gen dbg_seq_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .sel_i    (sel_i),
  .swdio_o  (swdio_o),
  .clk_en_o (clk_en_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/dbg_seq_gen_tb_top.sv
`timescale 1ns/1ps
module dbg_seq_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       swdio, clk_en, busy, done, err;

  always #2 clk = ~clk;

  dbg_seq_gen dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .sel_i    (sel),
    .swdio_o  (swdio),
    .clk_en_o (clk_en),
    .busy_o   (busy),
    .done_o   (done),
    .err_o    (err)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    finished = 0;
  bit    q[$];
  bit    m_busy, m_done, m_err;
  string tag = "R1";

  byte unsigned alert_bytes [16] = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
                                     8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void put(bit v, int n);
    for (int k = 0; k < n; k++) q.push_back(v);
  endfunction

  function automatic void put_code(longint unsigned v, int n);
    for (int k = 0; k < n; k++) q.push_back(bit'((v >> k) & 1));
  endfunction

  function automatic void put_alert();
    foreach (alert_bytes[b]) put_code(longint'(alert_bytes[b]), 8);
  endfunction

  function automatic void put_link_reset();
    put(1, 56); put(0, 8);
  endfunction

  function automatic void build(int s);
    q.delete();
    case (s)
      0: put_link_reset();
      1: begin put(1, 56); put_code(64'hE79E, 16); put_link_reset(); end
      2: begin put(1, 56); put_code(64'hE73C, 16); put(1, 8); end
      3: begin put(1, 56); put_code(64'hE3BC, 16); end
      4: begin put(1, 8); put_alert(); put(0, 4); put_code(64'h1A, 8); put(1, 68); put(0, 8); end
      5: begin put(1, 9); put_code(64'h33BBBBBA, 31); end
      6: begin put(1, 8); put_alert(); put(0, 24); end
      default: ;
    endcase
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_busy) begin
        void'(q.pop_front());
        if (q.size() == 0) begin m_busy = 0; m_done = 1; end
      end else if (start) begin
        if (sel == 3'd7) m_err = 1;
        else begin build(int'(sel)); m_busy = 1; end
      end
    end
  end

  // per-cycle compare, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == m_busy, tag, "busy", int'(busy), int'(m_busy));
      chk(clk_en == m_busy, tag, "clk_en", int'(clk_en), int'(m_busy));
      chk(done == m_done, (tag == "R12") ? "R12" : "R11", "done", int'(done), int'(m_done));
      chk(err == m_err, "R12", "err", int'(err), int'(m_err));
      chk(swdio == (m_busy ? q[0] : 1'b0), tag, "swdio", int'(swdio),
          int'(m_busy ? q[0] : 1'b0));
    end
  end

  task automatic run(int s, string t);
    @(negedge clk);
    tag = t; sel = 3'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1;
    chk(!busy && !done && !err && !clk_en && !swdio, "R1", "reset outputs",
        int'({busy, done, err, clk_en, swdio}), 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !clk_en && !swdio, "R1", "outputs in reset",
        int'({busy, done, err, clk_en, swdio}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !swdio, "R1", "idle after reset", int'({busy, swdio}), 0);

    run(0, "R3");
    run(1, "R4");
    run(2, "R5");
    run(3, "R6");
    run(4, "R7");   // alert content, R10
    run(5, "R8");
    run(6, "R9");   // alert content, R10

    // reserved select: error pulse, no run
    run(7, "R12");
    chk(!busy && !swdio, "R12", "line idle after reserved", int'({busy, swdio}), 0);

    // start while busy is ignored
    @(negedge clk);
    tag = "R13"; sel = 3'd2; start = 1'b1;
    @(negedge clk);
    sel = 3'd4;
    repeat (10) @(negedge clk);
    sel = 3'd0;
    repeat (30) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R13", "no follow-on run", int'(busy), 0);

    // held start: back-to-back runs, R2
    @(negedge clk);
    tag = "R2"; sel = 3'd5; start = 1'b1;
    repeat (95) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule